// File: doc/BRIEF.md
# Shared Writeback Port Arbiter

This block is a cycle-level timing model of the back end of a single-issue, in-order core. Every accepted instruction enters one of three pipes: integer, load/store or multiply-accumulate. The integer pipe writes through a register write port of its own. Loads and multiply-accumulate results share a second write port. Result values are modelled as tags, so each write carries the destination register and the tag that was given at issue.

Two sources compete for the shared port. Pipe results come from hitting loads and from multiply-accumulates that write a register. Data for missed loads comes back from external memory at any later cycle, because a miss does not hold up younger instructions. A reservation table that shifts once per cycle stalls issue before two pipe results can claim the same slot. Memory returns fill whatever slots the pipes leave free, and a one-entry holding register absorbs a return that collides with a pipe write. A fault abort raised while a load sits in its first cache stage removes that load and blocks the instruction offered in the same cycle.

Top module: `wb_port_arbiter`

## Requirements
- R1: The class code is 0 for integer, 1 for load, 2 for multiply-accumulate, and 3 is handled as integer. `issue_stall` is high for an offered load (`issue_valid`=1, class 1) when a multiply-accumulate with `issue_we`=1 was accepted in the previous cycle. Stalled instructions are not accepted. Integer and multiply-accumulate instructions are never stalled by the table.
- R2: An accepted integer instruction with `issue_we`=1 writes `wa_addr`=its register and `wa_data`=its tag with `wa_en` high exactly 2 cycles after acceptance. It never uses the shared port. With `issue_we`=0 it writes nothing.
- R3: An accepted load that sees `ld_hit`=1 in the cycle after acceptance (its first cache stage) writes its register and tag on the shared port exactly 3 cycles after acceptance.
- R4: An accepted multiply-accumulate with `issue_we`=1 writes on the shared port exactly 4 cycles after acceptance. With `issue_we`=0 it writes nothing.
- R5: A load that sees `ld_hit`=0 in its first cache stage makes no pipe write. Its data returns later through `mem_valid`/`mem_rd`/`mem_tag`.
- R6: `ld_abort` high while a load is in its first cache stage cancels that load, raises `issue_stall`, and rejects the instruction offered in that cycle. Older instructions still write. `ld_abort` has no effect when no load is in that stage.
- R7: A pipe write always takes the shared port ahead of memory data. A memory return accepted in a cycle with a pipe write is held and written in the first later cycle without a pipe write.
- R8: `mem_ready` is low exactly while the holding register is occupied. A return accepted with the holding register empty and no pipe write is written in the same cycle.
- R9: Each port makes at most one write per cycle, and every result is written exactly once.
- R10: During reset `wa_en` and `ws_en` are low, `mem_ready` is high and `issue_stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Instruction offered at issue |
| issue_cls | input | 2 | Pipe class code |
| issue_rd | input | AW | Destination register |
| issue_we | input | 1 | Instruction writes a register |
| issue_tag | input | TW | Result tag standing for the data |
| issue_stall | output | 1 | Offered instruction not accepted |
| ld_hit | input | 1 | Cache hit for the load in its first cache stage |
| ld_abort | input | 1 | Fault abort for the load in its first cache stage |
| mem_valid | input | 1 | Miss data returned by memory |
| mem_rd | input | AW | Register of the returned miss |
| mem_tag | input | TW | Tag of the returned miss |
| mem_ready | output | 1 | Return can be taken this cycle |
| wa_en | output | 1 | Integer port write enable |
| wa_addr | output | AW | Integer port register |
| wa_data | output | TW | Integer port tag |
| ws_en | output | 1 | Shared port write enable |
| ws_addr | output | AW | Shared port register |
| ws_data | output | TW | Shared port tag |

## Verification
A memory return can land in the same cycle as a pipe write on the shared port, and a load can be offered exactly one cycle after a writing multiply-accumulate. The first case is provoked directly by timing two misses so that their returns meet a run of three multiply-accumulate writes. This keeps the holding register full while a second return waits. The second case is provoked by back-to-back issue. Random traffic then mixes both with aborts and hits. A bench model predicts, cycle by cycle, the stall, the ready and both ports' register and tag, so a lost, delayed or repeated write shows up as a miscompare in the slot where it should have appeared.

// File: rtl/wbarb_pkg.sv
package wbarb_pkg;
  // Issue class encoding; code 3 is decoded as integer.
  typedef enum logic [1:0] {
    CLS_INT  = 2'd0,
    CLS_LOAD = 2'd1,
    CLS_MAC  = 2'd2,
    CLS_RSVD = 2'd3
  } cls_e;
endpackage

// File: rtl/wbarb_pipe.sv
// Delay line of valid/register/tag; stage 1 may be killed on its way on.
module wbarb_pipe #(
  parameter int DEPTH = 2,
  parameter int AW    = 5,
  parameter int TW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_vld,
  input  logic          in_we,
  input  logic [AW-1:0] in_rd,
  input  logic [TW-1:0] in_tag,
  input  logic          kill_s1,
  output logic          out_vld,
  output logic [AW-1:0] out_rd,
  output logic [TW-1:0] out_tag
);
  logic [DEPTH-1:0] vld_q, vld_n;
  logic [DEPTH-1:0] we_q;
  logic [AW-1:0]    rd_q  [DEPTH];
  logic [TW-1:0]    tag_q [DEPTH];

  always_comb begin
    vld_n[0] = in_vld;
    for (int k = 1; k < DEPTH; k++) begin
      vld_n[k] = vld_q[k-1] & ~((k == 1) & kill_s1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_n;
  end

  // Payload registers load only when their stage becomes valid.
  always_ff @(posedge clk) begin
    if (vld_n[0]) begin
      we_q[0]  <= in_we;
      rd_q[0]  <= in_rd;
      tag_q[0] <= in_tag;
    end
    for (int k = 1; k < DEPTH; k++) begin
      if (vld_n[k]) begin
        we_q[k]  <= we_q[k-1];
        rd_q[k]  <= rd_q[k-1];
        tag_q[k] <= tag_q[k-1];
      end
    end
  end

  assign out_vld = vld_q[DEPTH-1] & we_q[DEPTH-1];
  assign out_rd  = rd_q[DEPTH-1];
  assign out_tag = tag_q[DEPTH-1];
endmodule

// File: rtl/wbarb_rsv.sv
// Shared-port reservation table and issue stall. Latencies must be >= 3.
module wbarb_rsv #(
  parameter int LD_LAT  = 3,
  parameter int MAC_LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue_valid,
  input  logic is_ld,
  input  logic is_mac,
  input  logic issue_we,
  input  logic ld_abort,
  output logic issue_stall,
  output logic accept,
  output logic ld_d1
);
  localparam int RW = (LD_LAT > MAC_LAT) ? LD_LAT : MAC_LAT;

  // rsv_q[i]: shared port already claimed i cycles from now
  logic [RW:2] rsv_q, rsv_n;
  logic        d1_q, d1_n;

  always_comb begin
    issue_stall = (d1_q & ld_abort)
                | (issue_valid & is_ld & rsv_q[LD_LAT])
                | (issue_valid & is_mac & issue_we & rsv_q[MAC_LAT]);
    accept      = issue_valid & ~issue_stall;
    rsv_n       = {1'b0, rsv_q[RW:3]};
    if (accept & is_ld)             rsv_n[LD_LAT-1]  = 1'b1;
    if (accept & is_mac & issue_we) rsv_n[MAC_LAT-1] = 1'b1;
    d1_n        = accept & is_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsv_q <= '0;
      d1_q  <= 1'b0;
    end else begin
      rsv_q <= rsv_n;
      d1_q  <= d1_n;
    end
  end

  assign ld_d1 = d1_q;
endmodule

// File: rtl/wbarb_shared.sv
// Shared write port mux with a one-entry hold for memory returns.
module wbarb_shared #(
  parameter int AW = 5,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_v,
  input  logic [AW-1:0] ld_rd,
  input  logic [TW-1:0] ld_tag,
  input  logic          mac_v,
  input  logic [AW-1:0] mac_rd,
  input  logic [TW-1:0] mac_tag,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rd,
  input  logic [TW-1:0] mem_tag,
  output logic          mem_ready,
  output logic          ws_en,
  output logic [AW-1:0] ws_addr,
  output logic [TW-1:0] ws_data
);
  logic          hold_q, hold_n, hold_ld;
  logic [AW-1:0] hrd_q;
  logic [TW-1:0] htag_q;
  logic          pipe_v, mem_acc;

  always_comb begin
    pipe_v    = ld_v | mac_v;
    mem_ready = ~hold_q;
    mem_acc   = mem_valid & ~hold_q;
    ws_en     = pipe_v | hold_q | mem_acc;
    if (mac_v) begin
      ws_addr = mac_rd;
      ws_data = mac_tag;
    end else if (ld_v) begin
      ws_addr = ld_rd;
      ws_data = ld_tag;
    end else if (hold_q) begin
      ws_addr = hrd_q;
      ws_data = htag_q;
    end else begin
      ws_addr = mem_rd;
      ws_data = mem_tag;
    end
    hold_ld = mem_acc & pipe_v;
    hold_n  = hold_q ? pipe_v : hold_ld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_n;
  end

  always_ff @(posedge clk) begin
    if (hold_ld) begin
      hrd_q  <= mem_rd;
      htag_q <= mem_tag;
    end
  end
endmodule

// File: rtl/wb_port_arbiter.sv
module wb_port_arbiter
  import wbarb_pkg::*;
#(
  parameter int AW      = 5,
  parameter int TW      = 8,
  parameter int ALU_LAT = 2,
  parameter int LD_LAT  = 3,
  parameter int MAC_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [1:0]    issue_cls,
  input  logic [AW-1:0] issue_rd,
  input  logic          issue_we,
  input  logic [TW-1:0] issue_tag,
  output logic          issue_stall,
  input  logic          ld_hit,
  input  logic          ld_abort,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_rd,
  input  logic [TW-1:0] mem_tag,
  output logic          mem_ready,
  output logic          wa_en,
  output logic [AW-1:0] wa_addr,
  output logic [TW-1:0] wa_data,
  output logic          ws_en,
  output logic [AW-1:0] ws_addr,
  output logic [TW-1:0] ws_data
);
  cls_e          cls;
  logic          is_ld, is_mac, is_int, accept, ld_d1;
  logic          ld_v, mac_v;
  logic [AW-1:0] ld_rd, mac_rd;
  logic [TW-1:0] ld_tag, mac_tag;

  always_comb begin
    cls    = cls_e'(issue_cls);
    is_ld  = (cls == CLS_LOAD);
    is_mac = (cls == CLS_MAC);
    is_int = ~is_ld & ~is_mac;
  end

  wbarb_rsv #(.LD_LAT(LD_LAT), .MAC_LAT(MAC_LAT)) u_rsv (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .is_ld(is_ld),
    .is_mac(is_mac), .issue_we(issue_we), .ld_abort(ld_abort),
    .issue_stall(issue_stall), .accept(accept), .ld_d1(ld_d1)
  );

  wbarb_pipe #(.DEPTH(ALU_LAT), .AW(AW), .TW(TW)) u_alu (
    .clk(clk), .rst_n(rst_n), .in_vld(accept & is_int), .in_we(issue_we),
    .in_rd(issue_rd), .in_tag(issue_tag), .kill_s1(1'b0),
    .out_vld(wa_en), .out_rd(wa_addr), .out_tag(wa_data)
  );

  // Miss or abort in the first cache stage removes the load from the pipe.
  wbarb_pipe #(.DEPTH(LD_LAT), .AW(AW), .TW(TW)) u_ld (
    .clk(clk), .rst_n(rst_n), .in_vld(accept & is_ld), .in_we(1'b1),
    .in_rd(issue_rd), .in_tag(issue_tag),
    .kill_s1(ld_d1 & (ld_abort | ~ld_hit)),
    .out_vld(ld_v), .out_rd(ld_rd), .out_tag(ld_tag)
  );

  wbarb_pipe #(.DEPTH(MAC_LAT), .AW(AW), .TW(TW)) u_mac (
    .clk(clk), .rst_n(rst_n), .in_vld(accept & is_mac), .in_we(issue_we),
    .in_rd(issue_rd), .in_tag(issue_tag), .kill_s1(1'b0),
    .out_vld(mac_v), .out_rd(mac_rd), .out_tag(mac_tag)
  );

  wbarb_shared #(.AW(AW), .TW(TW)) u_shr (
    .clk(clk), .rst_n(rst_n),
    .ld_v(ld_v), .ld_rd(ld_rd), .ld_tag(ld_tag),
    .mac_v(mac_v), .mac_rd(mac_rd), .mac_tag(mac_tag),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_tag(mem_tag),
    .mem_ready(mem_ready), .ws_en(ws_en), .ws_addr(ws_addr), .ws_data(ws_data)
  );
endmodule

// File: rtl/wbarb_chk.sv
module wbarb_chk
  import wbarb_pkg::*;
#(
  parameter int AW      = 5,
  parameter int TW      = 8,
  parameter int ALU_LAT = 2,
  parameter int MAC_LAT = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_valid,
  input logic [1:0]    issue_cls,
  input logic          issue_we,
  input logic          issue_stall,
  input logic          ld_abort,
  input logic          mem_valid,
  input logic [AW-1:0] mem_rd,
  input logic [TW-1:0] mem_tag,
  input logic          mem_ready,
  input logic          wa_en,
  input logic          ws_en,
  input logic [AW-1:0] ws_addr,
  input logic [TW-1:0] ws_data
);
  logic acc, acc_ld, acc_mac_we, acc_int_we;
  assign acc        = issue_valid & ~issue_stall;
  assign acc_ld     = acc & (issue_cls == 2'(CLS_LOAD));
  assign acc_mac_we = acc & (issue_cls == 2'(CLS_MAC)) & issue_we;
  assign acc_int_we = acc & (issue_cls != 2'(CLS_LOAD)) & (issue_cls != 2'(CLS_MAC)) & issue_we;

  p_ld_after_mac_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && issue_valid && issue_cls == 2'(CLS_LOAD) && $past(acc_mac_we)
    |-> issue_stall);

  p_abort_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && $past(acc_ld) && ld_abort |-> issue_stall);

  p_int_writes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_int_we |-> ##ALU_LAT wa_en);

  p_mac_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_mac_we |-> ##MAC_LAT ws_en);

  p_collide_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && ws_en && (ws_addr != mem_rd || ws_data != mem_tag)
    |=> !mem_ready);

  p_full_writes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> ws_en);
endmodule

bind wb_port_arbiter wbarb_chk #(.AW(AW), .TW(TW), .ALU_LAT(ALU_LAT), .MAC_LAT(MAC_LAT)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_cls(issue_cls),
  .issue_we(issue_we), .issue_stall(issue_stall), .ld_abort(ld_abort),
  .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_tag(mem_tag), .mem_ready(mem_ready),
  .wa_en(wa_en), .ws_en(ws_en), .ws_addr(ws_addr), .ws_data(ws_data)
);

// File: tb/tb_wb_port_arbiter.sv
module tb_wb_port_arbiter;
  localparam int AW = 5;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          issue_valid, issue_we, issue_stall, ld_hit, ld_abort;
  logic [1:0]    issue_cls;
  logic [AW-1:0] issue_rd, mem_rd, wa_addr, ws_addr;
  logic [TW-1:0] issue_tag, mem_tag, wa_data, ws_data;
  logic          mem_valid, mem_ready, wa_en, ws_en;

  always #2 clk = ~clk;

  wb_port_arbiter dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_cls(issue_cls),
    .issue_rd(issue_rd), .issue_we(issue_we), .issue_tag(issue_tag),
    .issue_stall(issue_stall), .ld_hit(ld_hit), .ld_abort(ld_abort),
    .mem_valid(mem_valid), .mem_rd(mem_rd), .mem_tag(mem_tag), .mem_ready(mem_ready),
    .wa_en(wa_en), .wa_addr(wa_addr), .wa_data(wa_data),
    .ws_en(ws_en), .ws_addr(ws_addr), .ws_data(ws_data)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  // bench model
  int            cyc = 0;
  bit            m_lastmac = 0, m_d1 = 0, m_hold = 0, retry = 0, mem_keep = 0;
  logic [AW-1:0] m_d1_rd, m_hold_rd;
  logic [TW-1:0] m_d1_tag, m_hold_tag, next_tag = '0;
  bit            expA_v [8];
  logic [AW-1:0] expA_rd [8];
  logic [TW-1:0] expA_tag [8];
  bit            expS_v [8];
  logic [AW-1:0] expS_rd [8];
  logic [TW-1:0] expS_tag [8];
  string         expS_req [8];
  logic [AW-1:0] mq_rd [$];
  logic [TW-1:0] mq_tag [$];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic bit exp_stall_f();
    return (issue_valid && issue_cls == 2'd1 && m_lastmac) || (ld_abort && m_d1);
  endfunction

  task automatic eval_cycle();
    int s = cyc % 8;
    bit es = exp_stall_f();
    bit pipe = expS_v[s];
    bit e_en; logic [AW-1:0] e_rd; logic [TW-1:0] e_tag; string req;
    bit mem_acc = mem_valid && !m_hold;
    bit acc = issue_valid && !es;
    chk(issue_stall === es, (ld_abort && m_d1) ? "R6" : "R1", "issue_stall", issue_stall, es);
    chk(mem_ready === !m_hold, "R8", "mem_ready", mem_ready, !m_hold);
    chk(wa_en === expA_v[s], "R2", "wa_en", wa_en, expA_v[s]);
    if (wa_en === 1'b1 && expA_v[s]) begin
      chk(wa_addr === expA_rd[s], "R2", "wa_addr", wa_addr, expA_rd[s]);
      chk(wa_data === expA_tag[s], "R2", "wa_data", wa_data, expA_tag[s]);
    end
    if (pipe) begin
      e_en = 1; e_rd = expS_rd[s]; e_tag = expS_tag[s]; req = expS_req[s];
    end else if (m_hold) begin
      e_en = 1; e_rd = m_hold_rd; e_tag = m_hold_tag; req = "R7";
    end else if (mem_valid) begin
      e_en = 1; e_rd = mem_rd; e_tag = mem_tag; req = "R8";
    end else begin
      e_en = 0; e_rd = '0; e_tag = '0; req = expS_req[s];
    end
    chk(ws_en === e_en, req, "ws_en", ws_en, e_en);
    if (ws_en === 1'b1 && e_en) begin
      chk(ws_addr === e_rd, req, "ws_addr", ws_addr, e_rd);
      chk(ws_data === e_tag, req, "ws_data", ws_data, e_tag);
    end
    // advance model
    if (m_hold) begin
      if (!pipe) m_hold = 0;
    end else if (mem_acc && pipe) begin
      m_hold = 1; m_hold_rd = mem_rd; m_hold_tag = mem_tag;
    end
    if (mem_acc) begin void'(mq_rd.pop_front()); void'(mq_tag.pop_front()); end
    mem_keep = mem_valid && !mem_acc;
    expA_v[s] = 0; expS_v[s] = 0; expS_req[s] = "R9";
    if (m_d1) begin
      if (ld_abort) expS_req[(cyc+2)%8] = "R6";
      else if (ld_hit) begin
        expS_v[(cyc+2)%8] = 1; expS_rd[(cyc+2)%8] = m_d1_rd;
        expS_tag[(cyc+2)%8] = m_d1_tag; expS_req[(cyc+2)%8] = "R3";
      end else begin
        mq_rd.push_back(m_d1_rd); mq_tag.push_back(m_d1_tag);
        expS_req[(cyc+2)%8] = "R5";
      end
    end
    m_d1 = 0; m_lastmac = 0;
    if (acc) begin
      if (issue_cls == 2'd1) begin
        m_d1 = 1; m_d1_rd = issue_rd; m_d1_tag = issue_tag;
      end else if (issue_cls == 2'd2) begin
        m_lastmac = issue_we;
        if (issue_we) begin
          expS_v[(cyc+4)%8] = 1; expS_rd[(cyc+4)%8] = issue_rd;
          expS_tag[(cyc+4)%8] = issue_tag; expS_req[(cyc+4)%8] = "R4";
        end
      end else if (issue_we) begin
        expA_v[(cyc+2)%8] = 1; expA_rd[(cyc+2)%8] = issue_rd; expA_tag[(cyc+2)%8] = issue_tag;
      end
    end
    retry = issue_valid && es;
    cyc++;
  endtask

  task automatic drive(bit iv, logic [1:0] cls, logic [AW-1:0] rd, bit we,
                       bit hit, bit abort, bit mreq);
    if (!retry) begin
      issue_valid = iv; issue_cls = cls; issue_rd = rd; issue_we = we; issue_tag = next_tag;
      if (iv) next_tag++;
    end
    ld_hit = hit; ld_abort = abort;
    mem_valid = (mq_rd.size() > 0) && (mreq || mem_keep);
    if (mem_valid) begin mem_rd = mq_rd[0]; mem_tag = mq_tag[0]; end
    else begin mem_rd = '0; mem_tag = '0; end
    @(negedge clk);
    eval_cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(bit mreq);
    drive(0, 2'd0, '0, 0, 1, 0, mreq);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00c0ffee));
    for (int i = 0; i < 8; i++) begin
      expA_v[i] = 0; expS_v[i] = 0; expS_req[i] = "R9";
    end
    rst_n = 0; issue_valid = 0; issue_cls = 0; issue_rd = 0; issue_we = 0; issue_tag = 0;
    ld_hit = 0; ld_abort = 0; mem_valid = 0; mem_rd = 0; mem_tag = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    chk(wa_en === 1'b0, "R10", "wa_en", wa_en, 0);
    chk(ws_en === 1'b0, "R10", "ws_en", ws_en, 0);
    chk(mem_ready === 1'b1, "R10", "mem_ready", mem_ready, 1);
    chk(issue_stall === 1'b0, "R10", "issue_stall", issue_stall, 0);
    @(posedge clk); #1;
    rst_n = 1;

    // R1 R2 R4 R3: integer, writing MAC, load right behind it (stalled, retried)
    drive(1, 2'd0, 5'd3, 1, 1, 0, 0);
    drive(1, 2'd2, 5'd4, 1, 1, 0, 0);
    drive(1, 2'd1, 5'd5, 1, 1, 0, 0);
    idle(0);                       // retry of the load is accepted here
    drive(1, 2'd3, 5'd11, 0, 1, 0, 0);   // class 3, no write
    drive(1, 2'd2, 5'd12, 0, 1, 0, 0);   // MAC without write
    drive(1, 2'd1, 5'd13, 1, 1, 0, 0);   // load not stalled
    repeat (6) idle(0);

    // R5 R7 R8: two misses, three MAC writes, returns collide and back up
    drive(1, 2'd1, 5'd6, 1, 1, 0, 0);
    drive(1, 2'd1, 5'd7, 1, 0, 0, 0);
    drive(1, 2'd2, 5'd8, 1, 0, 0, 0);
    drive(1, 2'd2, 5'd9, 1, 1, 0, 0);
    drive(1, 2'd2, 5'd10, 1, 1, 0, 0);
    idle(0);
    repeat (8) idle(1);

    // R6: abort of a load in its first cache stage, then abort with none there
    drive(1, 2'd1, 5'd14, 1, 1, 0, 0);
    drive(1, 2'd0, 5'd15, 1, 1, 1, 0);
    idle(0);                       // retry of the integer instruction
    drive(1, 2'd0, 5'd16, 1, 1, 1, 0);
    repeat (4) idle(0);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      drive($urandom_range(0, 9) < 8, 2'($urandom_range(0, 3)), 5'($urandom),
            $urandom_range(0, 3) != 0, $urandom_range(0, 9) < 7,
            $urandom_range(0, 19) == 0, $urandom_range(0, 9) < 4);
    end

    // drain: every miss must come back and be written once (R9)
    for (int n = 0; n < 400 && (mq_rd.size() > 0 || m_hold || retry); n++) idle(1);
    repeat (8) idle(0);
    chk(mq_rd.size() == 0 && !m_hold, "R9", "outstanding misses", mq_rd.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule